// File: doc/BRIEF.md
# Peripheral Clock Enable Controller

This block holds the clock-enable bit of every peripheral on a chip and drives one enable line per peripheral identifier toward the clock gating cells. Software never writes the enable state directly. Instead, each 32-identifier bank has three registers:

- a set register, where every 1 written switches that clock on;
- a clear register, where every 1 written switches that clock off;
- a status register that returns the bank's current enables.

Zeros written to the set or clear register leave the matching enables alone. Several drivers can therefore change their own peripherals without a read-modify-write sequence.

Identifier `n` sits in bank `n / 32` at bit `n % 32`. The lowest identifiers are permanently on, and no write can turn them off. Access is over a simple synchronous register bus with byte addresses. Each bank occupies a 16-byte window:

- offset 0x0 is the set register;
- offset 0x4 is the clear register;
- offset 0x8 is the status register.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: While reset is low, and on the first cycles after it, the enable vector is all zero except identifiers 0 and 1. Status of bank 0 (address 0x08) reads 0x00000003, and status of bank 1 (address 0x18) reads 0x00000000.
- R2: A write to a bank's set register (0x00 bank 0, 0x10 bank 1) turns on each identifier whose data bit is 1. Bits written 0 keep their value. The enable vector shows the change right after the clock edge that takes the write.
- R3: A write to a bank's clear register (0x04 bank 0, 0x14 bank 1) turns off each identifier whose data bit is 1. Bits written 0 keep their value. The change is visible after the same edge as in R2.
- R4: A read of a status register (0x08 bank 0, 0x18 bank 1) returns that bank's 32 enable bits, bit `k` being identifier `bank*32+k`. The data is on the read-data port in the cycle after the read strobe, and shows the enables as they were when the strobe was taken.
- R5: Identifiers 32 to 63 are controlled only through the bank 1 registers, at bit position identifier minus 32, and drive enable outputs 32 to 63.
- R6: Identifiers 0 and 1 read as 1 and stay enabled. Set and clear writes to their bits do nothing.
- R7: Several accesses return zero and leave every enable unchanged when written:
  - reads of the set and clear registers;
  - reads of offset 0xC in either bank;
  - reads and writes at addresses whose two low bits are not zero.

  Writes to a status register are also ignored. Read data is zero in any cycle after one without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, taken at the rising edge |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| clk_en | output | 64 | One clock enable per peripheral identifier |

## Verification
A write updates the enable outputs on the clock edge that takes it, with no further delay. The bench therefore raises the strobe on a falling edge and compares `clk_en` at the next falling edge. Read data passes through one register, so a status value is compared at the falling edge that follows the rising edge that took the strobe. Checking the zero-when-idle rule means sampling one full cycle after the strobe drops. Mid-run reset is checked on the falling edge after a reset edge.

// File: rtl/pcg_pkg.sv
// Package for the peripheral clock enable controller.
// Holds the register-select encoding and the mask helpers used per bank.
// Assumes banks of exactly 32 identifiers.
package pcg_pkg;

    localparam int BANK_W = 32;

    // Register select, taken from byte-address bits [3:2].
    typedef enum logic [1:0] {
        SEL_SET  = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Bits of a bank that are permanently on (identifier below always_on).
    function automatic logic [BANK_W-1:0] on_mask(input int base, input int always_on);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) m[i] = ((base + i) < always_on);
        return m;
    endfunction

    // Bits of a bank that software may change.
    function automatic logic [BANK_W-1:0] wr_mask(input int base, input int always_on,
                                                  input int num_periph);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++)
            m[i] = ((base + i) >= always_on) && ((base + i) < num_periph);
        return m;
    endfunction

endpackage

// File: rtl/pcg_decode.sv
// Address decoder.
// Turns a bus access into per-bank set and clear strobes and a status read request.
// Assumes byte addresses, with a 16-byte window per bank starting at zero.
// Misaligned addresses, out-of-range banks and offset 0xC produce no strobe.
module pcg_decode #(
    parameter int ADDR_W    = 5,
    parameter int NUM_BANKS = 2,
    localparam int BIDX_W   = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output logic [NUM_BANKS-1:0] set_stb,
    output logic [NUM_BANKS-1:0] clr_stb,
    output logic              rd_hit,
    output logic [BIDX_W-1:0] rd_bank
);
    import pcg_pkg::*;

    logic [BIDX_W-1:0] bank_idx;
    reg_sel_e          sel;
    logic              valid;

    assign bank_idx = addr[ADDR_W-1:4];
    assign sel      = reg_sel_e'(addr[3:2]);
    assign valid    = (addr[1:0] == 2'b00) && (int'(bank_idx) < NUM_BANKS);

    // Per-bank write strobes.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
            assign set_stb[b] = we && valid && (int'(bank_idx) == b) && (sel == SEL_SET);
            assign clr_stb[b] = we && valid && (int'(bank_idx) == b) && (sel == SEL_CLR);
        end
    endgenerate

    // Status read request and the bank it targets.
    always_comb begin
        rd_hit  = re && valid && (sel == SEL_STAT);
        rd_bank = bank_idx;
    end

endmodule

// File: rtl/pcg_bank.sv
// One bank of 32 peripheral clock enables.
// Set and clear strobes apply write-one semantics.
// Clear has priority should both strobes ever arrive in the same cycle.
// Permanently-on and non-existent identifiers are tied off by parameter.
module pcg_bank #(
    parameter int BASE_ID    = 0,
    parameter int ALWAYS_ON  = 2,
    parameter int NUM_PERIPH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_stb,
    input  logic        clr_stb,
    input  logic [31:0] wdata,
    output logic [31:0] en
);
    import pcg_pkg::*;

    localparam logic [BANK_W-1:0] ON_M = on_mask(BASE_ID, ALWAYS_ON);
    localparam logic [BANK_W-1:0] WR_M = wr_mask(BASE_ID, ALWAYS_ON, NUM_PERIPH);

    logic [BANK_W-1:0] en_q;

    // Enable state: write-one set or clear, writable bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (clr_stb)
            en_q <= en_q & ~(wdata & WR_M);
        else if (set_stb)
            en_q <= (en_q | wdata) & WR_M;
    end

    assign en = en_q | ON_M;

endmodule

// File: rtl/pcg_rdata.sv
// Registered read-data path.
// Returns the status of the selected bank one cycle after a status read, and zero otherwise.
module pcg_rdata #(
    parameter int NUM_BANKS = 2,
    parameter int BIDX_W    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_hit,
    input  logic [BIDX_W-1:0]       rd_bank,
    input  logic [NUM_BANKS*32-1:0] status,
    output logic [31:0]             rdata
);

    logic [31:0] sel_word;

    // Select the bank word; out-of-range banks never raise rd_hit.
    always_comb begin
        sel_word = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (int'(rd_bank) == b) sel_word = status[b*32 +: 32];
    end

    // Read-data register, cleared when there is no status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_hit ? sel_word : '0;
    end

endmodule

// File: rtl/pclk_gate_ctrl.sv
// Peripheral clock enable controller, top level.
// Drives one clock-enable line per peripheral identifier.
// Enables change through per-bank set and clear registers; status is read back per bank.
// Assumes ADDR_W leaves room for all banks at a 16-byte stride.
module pclk_gate_ctrl #(
    parameter int NUM_PERIPH = 64,
    parameter int ALWAYS_ON  = 2,
    parameter int ADDR_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_re,
    output logic [31:0]           bus_rdata,
    output logic [NUM_PERIPH-1:0] clk_en
);
    localparam int NUM_BANKS = (NUM_PERIPH + 31) / 32;
    localparam int BIDX_W    = ADDR_W - 4;

    logic [NUM_BANKS-1:0]    set_stb;
    logic [NUM_BANKS-1:0]    clr_stb;
    logic                    rd_hit;
    logic [BIDX_W-1:0]       rd_bank;
    logic [NUM_BANKS*32-1:0] all_en;

    pcg_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .re      (bus_re),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .rd_hit  (rd_hit),
        .rd_bank (rd_bank)
    );

    // One bank instance per 32 identifiers.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            pcg_bank #(
                .BASE_ID    (b * 32),
                .ALWAYS_ON  (ALWAYS_ON),
                .NUM_PERIPH (NUM_PERIPH)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_stb (set_stb[b]),
                .clr_stb (clr_stb[b]),
                .wdata   (bus_wdata),
                .en      (all_en[b*32 +: 32])
            );
        end
    endgenerate

    pcg_rdata #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (rd_hit),
        .rd_bank (rd_bank),
        .status  (all_en),
        .rdata   (bus_rdata)
    );

    assign clk_en = all_en[NUM_PERIPH-1:0];

endmodule

// File: rtl/pcg_gate_chk.sv
// Assertion checker for pclk_gate_ctrl, attached by bind.
// Assumes the default map: at least 32 identifiers and 5 address bits.
module pcg_gate_chk #(
    parameter int NUM_PERIPH = 64,
    parameter int ADDR_W     = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [31:0]           bus_wdata,
    input logic                  bus_re,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PERIPH-1:0] clk_en
);

    // R6: the two lowest identifiers are always on.
    p_always_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[1:0] == 2'b11);

    // R2: after a bank 0 set write, every written 1 is enabled.
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h00)) |=>
        ((clk_en[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: after a bank 0 clear write, every written 1 above bit 1 is off.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h04)) |=>
        ((clk_en[31:0] & $past(bus_wdata) & ~32'h3) == 32'h0));

    // R4: a bank 0 status read returns the enables at the time of the strobe.
    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(8'h08)) |=>
        (bus_rdata == $past(clk_en[31:0])));

    // R7: without a write, the enables do not move.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(clk_en));

    // R7: no read strobe means zero read data next cycle.
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == 32'h0));

endmodule

bind pclk_gate_ctrl pcg_gate_chk #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en)
);

// File: tb/pclk_gate_ctrl_test.sv
`timescale 1ns/1ps
module pclk_gate_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] clk_en;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pclk_gate_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en)
    );

    // is_rd: 0 = write then compare clk_en to exp; 1 = read then compare rdata to exp[31:0].
    typedef struct packed {
        logic [3:0]  req;
        logic        is_rd;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 1'b0, 5'h00, 32'h000000F0, 64'h00000000_000000F3}, // R2 set
        '{4'd4, 1'b1, 5'h08, 32'h0,        64'h00000000_000000F3}, // R4 status
        '{4'd2, 1'b0, 5'h00, 32'h00000000, 64'h00000000_000000F3}, // R2 zeros
        '{4'd3, 1'b0, 5'h04, 32'h00000030, 64'h00000000_000000C3}, // R3 clear
        '{4'd6, 1'b0, 5'h04, 32'h00000003, 64'h00000000_000000C3}, // R6 clear ignored
        '{4'd5, 1'b0, 5'h10, 32'h80000001, 64'h80000001_000000C3}, // R5 ids 32, 63
        '{4'd5, 1'b1, 5'h18, 32'h0,        64'h00000000_80000001}, // R5 status bank 1
        '{4'd7, 1'b1, 5'h10, 32'h0,        64'h0},                 // R7 read set reg
        '{4'd7, 1'b1, 5'h04, 32'h0,        64'h0},                 // R7 read clear reg
        '{4'd7, 1'b0, 5'h0C, 32'hFFFFFFFF, 64'h80000001_000000C3}, // R7 reserved write
        '{4'd7, 1'b1, 5'h0C, 32'h0,        64'h0},                 // R7 reserved read
        '{4'd3, 1'b0, 5'h14, 32'h80000000, 64'h00000001_000000C3}, // R3 bank 1 clear
        '{4'd2, 1'b0, 5'h00, 32'hFFFFFFFF, 64'h00000001_FFFFFFFF}, // R2 all set
        '{4'd4, 1'b1, 5'h08, 32'h0,        64'h00000000_FFFFFFFF}, // R4 status
        '{4'd3, 1'b0, 5'h04, 32'hFFFFFFFF, 64'h00000001_00000003}, // R3 all clear
        '{4'd6, 1'b1, 5'h08, 32'h0,        64'h00000000_00000003}  // R6 status bits 0,1
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write strobe for one cycle; enables are updated by the next falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Read strobe for one cycle; read data is registered by the next falling edge.
    task automatic rd(input logic [4:0] a);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset enables", clk_en, 64'h3);
        rst_n = 1'b1;
        chk("R1 enables after release", clk_en, 64'h3);
        rd(5'h08);
        chk("R1 bank0 status", {32'h0, bus_rdata}, 64'h3);
        rd(5'h18);
        chk("R1 bank1 status", {32'h0, bus_rdata}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VEC[i].req, i);
            if (VEC[i].is_rd) begin
                rd(VEC[i].addr);
                chk(tag, {32'h0, bus_rdata}, {32'h0, VEC[i].exp[31:0]});
            end else begin
                wr(VEC[i].addr, VEC[i].data);
                chk(tag, clk_en, VEC[i].exp);
            end
        end

        // R7: read data returns to zero one cycle after the strobe drops.
        @(negedge clk);
        chk("R7 idle rdata", {32'h0, bus_rdata}, 64'h0);

        // R7: misaligned set write has no effect.
        wr(5'h11, 32'hFFFFFFFF);
        chk("R7 misaligned write", clk_en, 64'h00000001_00000003);

        // R7: write to status register ignored while reading it in the same cycle (R4).
        @(negedge clk);
        bus_addr = 5'h18; bus_wdata = 32'hFFFF0000; bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        chk("R7 status write ignored", clk_en, 64'h00000001_00000003);
        chk("R4 status with write", {32'h0, bus_rdata}, 64'h1);

        // R1: mid-run reset returns to the reset state.
        wr(5'h10, 32'h0000FF00);
        chk("R5 bank1 set", clk_en, 64'h0000FF01_00000003);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", clk_en, 64'h3);
        rst_n = 1'b1;
        rd(5'h18);
        chk("R1 bank1 status after reset", {32'h0, bus_rdata}, 64'h0);

        finish_run();
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            $display("FAIL all: actual timeout expected completion");
            finish_run();
        end
    end

endmodule